// File: doc/BRIEF.md
# S-box Lookup Execution Unit

This unit is the execute stage of a small cipher coprocessor. It speeds up the Feistel round function that combines four S-box words. Six instructions make up one round. Four address instructions each take one byte of the right half R, turn it into a word address inside one S-box, and latch that address in a special register. The fifth instruction (AX) combines the first three lookup words. The sixth (AXX) folds the fourth word, the round key and the left half LL into the new left half.

The memory read is split off into a separate lookup stage that is fed by the special register. An address instruction therefore finishes in a single cycle, and the next instruction issues at once. The lookup word returns two cycles after its address instruction. It is published on a bypass and write-back port, and it is stored in a local operand register. A combine instruction that issues in the very cycle a word returns takes the returning word directly. For this reason all six instructions of one round can issue back-to-back with no stall.

Top module: `sbox_exu`

## Requirements
- R1: With iss_valid high, opcodes 0 to 3 select S-boxes 1 to 4. Each takes the byte R[31:24], R[23:16], R[15:8] or R[7:0] respectively. The word address it forms is BASE + 256*box + byte, where box is the opcode (0 to 3).
- R2: In the cycle after an address instruction, mem_re is high and mem_addr carries its address. mem_re is low in every cycle that does not follow an address instruction.
- R3: Two cycles after an address instruction, lk_valid is high, lk_box equals its opcode, lk_dst equals its iss_dst, and lk_data equals the word the memory returned. lk_valid is low otherwise.
- R4: A combine instruction that issues in the cycle a lookup word returns uses that word. In later cycles it uses the stored word of that box.
- R5: AX (opcode 4) computes T = (t1 + t2) XOR t3, with the addition modulo 2^32. T is stored for later AXX instructions, and it appears on alu_data with alu_dst = iss_dst and alu_valid high in the next cycle.
- R6: AX with iss_nox high computes T = t1 + t2 and ignores t3.
- R7: AXX (opcode 5) yields iss_ll XOR iss_key XOR (T + t4) on the ALU port in the next cycle. T is the value of the latest AX.
- R8: The six-instruction round S1, S2, S3, S4, AX, AXX issued on consecutive cycles gives the correct results with no stall.
- R9: After reset no read, lookup or ALU output is valid, and the stored words t1 to t4 and T are zero.
- R10: An issue with iss_valid low, or with opcode 6 or 7, starts no read, produces no ALU result and changes no stored word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| iss_valid | input | 1 | Instruction issued this cycle |
| iss_op | input | 3 | Opcode: 0-3 S-box address, 4 AX, 5 AXX |
| iss_dst | input | 5 | Destination register index |
| iss_nox | input | 1 | AX treats t3 as zero |
| iss_r | input | 32 | Right half R |
| iss_ll | input | 32 | Left half LL (AXX) |
| iss_key | input | 32 | Round key P (AXX) |
| mem_re | output | 1 | S-box memory read enable |
| mem_addr | output | ADDR_W | S-box word address |
| mem_rdata | input | 32 | Read word, one cycle after mem_re |
| lk_valid | output | 1 | Lookup word valid (bypass and write-back) |
| lk_box | output | 2 | S-box index of the lookup word |
| lk_dst | output | 5 | Destination register of the lookup word |
| lk_data | output | 32 | Lookup word |
| alu_valid | output | 1 | Combine result valid |
| alu_dst | output | 5 | Destination register of the combine result |
| alu_data | output | 32 | Combine result |

## Verification
Single address instructions spaced by idle cycles check the byte lane and box base of each opcode on an R whose four bytes all differ, so a swapped lane shows up. Full rounds issued back-to-back force AX and AXX to take the word returning in their own cycle while the earlier words come from storage; isolated combines after idle cycles exercise only the stored path, so the two separate a broken bypass from broken storage. AX with t3 masked, AX and AXX straight after reset, and invalid or unused opcodes slipped between rounds cover the plain-add variant, the zeroed state and the no-effect cases.

// File: rtl/sbox_pkg.sv
package sbox_pkg;
    localparam int NBOX      = 4;
    localparam int WORD_W    = 32;
    localparam int BYTE_W    = 8;
    localparam int BOX_SEL_W = $clog2(NBOX);
    localparam int DST_W     = 5;
    localparam int OP_W      = 3;
    localparam logic [OP_W-1:0] OP_AX  = 3'd4;
    localparam logic [OP_W-1:0] OP_AXX = 3'd5;
endpackage

// File: rtl/sbox_agen.sv
module sbox_agen
    import sbox_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int BASE   = 0
) (
    input  logic [BOX_SEL_W-1:0] box,
    input  logic [WORD_W-1:0]    r,
    output logic [ADDR_W-1:0]    addr
);
    logic [NBOX-1:0][BYTE_W-1:0] lanes;

    // box 0 takes the top byte, box NBOX-1 the bottom byte
    for (genvar g = 0; g < NBOX; g++) begin : g_lane
        assign lanes[g] = r[WORD_W-1-g*BYTE_W -: BYTE_W];
    end

    assign addr = ADDR_W'(BASE) + ADDR_W'({box, lanes[box]});
endmodule

// File: rtl/sbox_lookup.sv
module sbox_lookup
    import sbox_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          req_v,
    input  logic [BOX_SEL_W-1:0]          req_box,
    input  logic [DST_W-1:0]              req_dst,
    input  logic [ADDR_W-1:0]             req_addr,
    input  logic [WORD_W-1:0]             mem_rdata,
    output logic                          mem_re,
    output logic [ADDR_W-1:0]             mem_addr,
    output logic                          lk_valid,
    output logic [BOX_SEL_W-1:0]          lk_box,
    output logic [DST_W-1:0]              lk_dst,
    output logic [NBOX-1:0][WORD_W-1:0]   t_eff
);
    typedef struct packed {
        logic                        spr_v;
        logic [BOX_SEL_W-1:0]        spr_box;
        logic [DST_W-1:0]            spr_dst;
        logic [ADDR_W-1:0]           spr_addr;
        logic                        rd_v;
        logic [BOX_SEL_W-1:0]        rd_box;
        logic [DST_W-1:0]            rd_dst;
        logic [NBOX-1:0][WORD_W-1:0] t;
    } lk_state_t;

    lk_state_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.spr_v = req_v;
        if (req_v) begin
            st_d.spr_box  = req_box;
            st_d.spr_dst  = req_dst;
            st_d.spr_addr = req_addr;
        end
        st_d.rd_v   = st_q.spr_v;
        st_d.rd_box = st_q.spr_box;
        st_d.rd_dst = st_q.spr_dst;
        if (st_q.rd_v) begin
            st_d.t[st_q.rd_box] = mem_rdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // bypass: a word returning this cycle overrides the stored copy
    for (genvar g = 0; g < NBOX; g++) begin : g_byp
        assign t_eff[g] = (st_q.rd_v && st_q.rd_box == BOX_SEL_W'(g)) ? mem_rdata : st_q.t[g];
    end

    assign mem_re   = st_q.spr_v;
    assign mem_addr = st_q.spr_addr;
    assign lk_valid = st_q.rd_v;
    assign lk_box   = st_q.rd_box;
    assign lk_dst   = st_q.rd_dst;
endmodule

// File: rtl/sbox_combine.sv
module sbox_combine
    import sbox_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        do_ax,
    input  logic                        do_axx,
    input  logic                        nox,
    input  logic [DST_W-1:0]            dst,
    input  logic [WORD_W-1:0]           ll,
    input  logic [WORD_W-1:0]           key,
    input  logic [NBOX-1:0][WORD_W-1:0] t_eff,
    output logic                        res_v,
    output logic [DST_W-1:0]            res_dst,
    output logic [WORD_W-1:0]           res_data
);
    typedef struct packed {
        logic [WORD_W-1:0] acc;
        logic              v;
        logic [DST_W-1:0]  dst;
        logic [WORD_W-1:0] data;
    } cb_state_t;

    cb_state_t st_d, st_q;
    logic [WORD_W-1:0] ax_val;

    always_comb begin
        ax_val = (t_eff[0] + t_eff[1]) ^ (nox ? '0 : t_eff[2]);
        st_d   = st_q;
        st_d.v = do_ax || do_axx;
        if (do_ax || do_axx) begin
            st_d.dst = dst;
        end
        if (do_ax) begin
            st_d.acc  = ax_val;
            st_d.data = ax_val;
        end else if (do_axx) begin
            st_d.data = ll ^ key ^ (st_q.acc + t_eff[3]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign res_v    = st_q.v;
    assign res_dst  = st_q.dst;
    assign res_data = st_q.data;
endmodule

// File: rtl/sbox_exu.sv
module sbox_exu
    import sbox_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int BASE   = 0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 iss_valid,
    input  logic [OP_W-1:0]      iss_op,
    input  logic [DST_W-1:0]     iss_dst,
    input  logic                 iss_nox,
    input  logic [WORD_W-1:0]    iss_r,
    input  logic [WORD_W-1:0]    iss_ll,
    input  logic [WORD_W-1:0]    iss_key,
    output logic                 mem_re,
    output logic [ADDR_W-1:0]    mem_addr,
    input  logic [WORD_W-1:0]    mem_rdata,
    output logic                 lk_valid,
    output logic [BOX_SEL_W-1:0] lk_box,
    output logic [DST_W-1:0]     lk_dst,
    output logic [WORD_W-1:0]    lk_data,
    output logic                 alu_valid,
    output logic [DST_W-1:0]     alu_dst,
    output logic [WORD_W-1:0]    alu_data
);
    logic                        is_lk, is_ax, is_axx;
    logic [ADDR_W-1:0]           req_addr;
    logic [NBOX-1:0][WORD_W-1:0] t_eff;

    assign is_lk  = iss_valid && !iss_op[OP_W-1];
    assign is_ax  = iss_valid && (iss_op == OP_AX);
    assign is_axx = iss_valid && (iss_op == OP_AXX);

    sbox_agen #(.ADDR_W(ADDR_W), .BASE(BASE)) u_agen (
        .box  (iss_op[BOX_SEL_W-1:0]),
        .r    (iss_r),
        .addr (req_addr)
    );

    sbox_lookup #(.ADDR_W(ADDR_W)) u_lookup (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_v     (is_lk),
        .req_box   (iss_op[BOX_SEL_W-1:0]),
        .req_dst   (iss_dst),
        .req_addr  (req_addr),
        .mem_rdata (mem_rdata),
        .mem_re    (mem_re),
        .mem_addr  (mem_addr),
        .lk_valid  (lk_valid),
        .lk_box    (lk_box),
        .lk_dst    (lk_dst),
        .t_eff     (t_eff)
    );

    assign lk_data = mem_rdata;

    sbox_combine u_combine (
        .clk      (clk),
        .rst_n    (rst_n),
        .do_ax    (is_ax),
        .do_axx   (is_axx),
        .nox      (iss_nox),
        .dst      (iss_dst),
        .ll       (iss_ll),
        .key      (iss_key),
        .t_eff    (t_eff),
        .res_v    (alu_valid),
        .res_dst  (alu_dst),
        .res_data (alu_data)
    );
endmodule

// File: rtl/sbox_exu_chk.sv
module sbox_exu_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       iss_valid,
    input logic [2:0] iss_op,
    input logic       mem_re,
    input logic       lk_valid,
    input logic [1:0] lk_box,
    input logic       alu_valid
);
    // R2
    read_follows_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && !iss_op[2]) |=> mem_re);
    // R2
    no_stray_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(iss_valid && !iss_op[2]) |=> !mem_re);
    // R3
    lookup_returns_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_re |=> lk_valid);
    // R3
    lookup_box_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && !iss_op[2]) |=> ##1 (lk_box == $past(iss_op[1:0], 2)));
    // R5
    combine_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && (iss_op == 3'd4 || iss_op == 3'd5)) |=> alu_valid);
    // R10
    no_stray_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(iss_valid && (iss_op == 3'd4 || iss_op == 3'd5)) |=> !alu_valid);
endmodule

bind sbox_exu sbox_exu_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .iss_valid (iss_valid),
    .iss_op    (iss_op),
    .mem_re    (mem_re),
    .lk_valid  (lk_valid),
    .lk_box    (lk_box),
    .alu_valid (alu_valid)
);

// File: tb/sbox_exu_test.sv
`timescale 1ns/1ps
module sbox_exu_test;
    localparam int AW = 12;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        iss_valid = 0;
    logic [2:0]  iss_op = 0;
    logic [4:0]  iss_dst = 0;
    logic        iss_nox = 0;
    logic [31:0] iss_r = 0, iss_ll = 0, iss_key = 0;
    logic        mem_re;
    logic [AW-1:0] mem_addr;
    logic [31:0] mem_rdata = 0;
    logic        lk_valid;
    logic [1:0]  lk_box;
    logic [4:0]  lk_dst;
    logic [31:0] lk_data;
    logic        alu_valid;
    logic [4:0]  alu_dst;
    logic [31:0] alu_data;

    int total = 0, bad = 0, cyc = 0;

    sbox_exu #(.ADDR_W(AW), .BASE(0)) uut (.*);

    always #2.5 clk = ~clk;

    function automatic logic [31:0] mem_word(input logic [AW-1:0] a);
        return (32'(a) * 32'h9E3779B1) ^ 32'hC3A5_0F1E;
    endfunction

    always @(posedge clk) if (mem_re) mem_rdata <= mem_word(mem_addr);

    // reference state
    logic [31:0] tm [4];
    logic [31:0] tm_T;
    bit          e_mre  [int];
    logic [AW-1:0] e_maddr [int];
    bit          e_lkv  [int];
    logic [1:0]  e_lkbox [int];
    logic [4:0]  e_lkdst [int];
    logic [31:0] e_lkdat [int];
    bit          e_av   [int];
    logic [4:0]  e_adst [int];
    logic [31:0] e_adat [int];
    string       e_atag [int];

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s cycle %0d: actual %h expected %h", tag, cyc, act, exp);
        end
    endtask

    function automatic logic [31:0] t_now(input int b);
        if (e_lkv.exists(cyc) && e_lkbox[cyc] == 2'(b)) return e_lkdat[cyc];
        return tm[b];
    endfunction

    task automatic step(input bit v, input logic [2:0] op, input logic [4:0] dst,
                        input logic [31:0] r, input logic [31:0] ll, input logic [31:0] key,
                        input bit nox, input string tag);
        logic [31:0] newT;
        bit setT;
        logic [AW-1:0] a;
        setT = 0;
        newT = 0;
        iss_valid = v; iss_op = op; iss_dst = dst; iss_r = r;
        iss_ll = ll; iss_key = key; iss_nox = nox;
        if (v && op < 3'd4) begin
            a = AW'(op) * AW'(256) + AW'(r[31 - 8*int'(op) -: 8]);   // R1
            e_mre[cyc+1] = 1; e_maddr[cyc+1] = a;
            e_lkv[cyc+2] = 1; e_lkbox[cyc+2] = op[1:0];
            e_lkdst[cyc+2] = dst; e_lkdat[cyc+2] = mem_word(a);
        end else if (v && op == 3'd4) begin
            newT = (t_now(0) + t_now(1)) ^ (nox ? 32'd0 : t_now(2));
            setT = 1;
            e_av[cyc+1] = 1; e_adst[cyc+1] = dst; e_adat[cyc+1] = newT; e_atag[cyc+1] = tag;
        end else if (v && op == 3'd5) begin
            e_av[cyc+1] = 1; e_adst[cyc+1] = dst;
            e_adat[cyc+1] = ll ^ key ^ (tm_T + t_now(3)); e_atag[cyc+1] = tag;
        end
        #1;
        // R2 read port
        chk("R2 mem_re", 32'(mem_re), 32'(e_mre.exists(cyc)));
        if (e_mre.exists(cyc)) chk("R1 mem_addr", 32'(mem_addr), 32'(e_maddr[cyc]));
        // R3 lookup port
        chk("R3 lk_valid", 32'(lk_valid), 32'(e_lkv.exists(cyc)));
        if (e_lkv.exists(cyc)) begin
            chk("R3 lk_box", 32'(lk_box), 32'(e_lkbox[cyc]));
            chk("R3 lk_dst", 32'(lk_dst), 32'(e_lkdst[cyc]));
            chk("R3 lk_data", lk_data, e_lkdat[cyc]);
        end
        chk(e_av.exists(cyc) ? e_atag[cyc] : "R10 alu_valid", 32'(alu_valid), 32'(e_av.exists(cyc)));
        if (e_av.exists(cyc)) begin
            chk({e_atag[cyc], " alu_dst"}, 32'(alu_dst), 32'(e_adst[cyc]));
            chk({e_atag[cyc], " alu_data"}, alu_data, e_adat[cyc]);
        end
        // commit reference state at end of cycle
        if (e_lkv.exists(cyc)) tm[e_lkbox[cyc]] = e_lkdat[cyc];
        if (setT) tm_T = newT;
        @(negedge clk);
        cyc++;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, 3'd0, 5'd0, 32'h0, 32'h0, 32'h0, 0, "R10");
    endtask

    task automatic round(input logic [31:0] r, input logic [31:0] ll, input logic [31:0] key);
        // R8 back-to-back round; R4 bypass on AX (t3) and AXX (t4)
        step(1, 3'd0, 5'd1, r, 0, 0, 0, "R8");
        step(1, 3'd1, 5'd2, r, 0, 0, 0, "R8");
        step(1, 3'd2, 5'd3, r, 0, 0, 0, "R8");
        step(1, 3'd3, 5'd4, r, 0, 0, 0, "R8");
        step(1, 3'd4, 5'd5, 0, 0, 0, 0, "R4 R5 AX bypass");
        step(1, 3'd5, 5'd6, 0, ll, key, 0, "R4 R7 AXX bypass");
    endtask

    initial begin
        for (int i = 0; i < 4; i++) tm[i] = 0;
        tm_T = 0;
        repeat (3) @(negedge clk);
        #1;
        // R9 reset state
        chk("R9 mem_re", 32'(mem_re), 0);
        chk("R9 lk_valid", 32'(lk_valid), 0);
        chk("R9 alu_valid", 32'(alu_valid), 0);
        rst_n = 1;
        @(negedge clk);
        // R9 stored words zero: AX then AXX straight after reset
        step(1, 3'd4, 5'd7, 0, 0, 0, 0, "R9 AX zero");
        step(1, 3'd5, 5'd8, 0, 32'h5, 32'h3, 0, "R9 AXX zero");
        // R1 single lookups, spaced
        for (int b = 0; b < 4; b++) begin
            step(1, 3'(b), 5'(10 + b), 32'hA1B2_C3D4, 0, 0, 0, "R1");
            idle(3);
        end
        // R4 stored path only
        step(1, 3'd4, 5'd9, 0, 0, 0, 0, "R5 AX stored");
        step(1, 3'd5, 5'd9, 0, 32'h1234_5678, 32'h0F0F_0F0F, 0, "R7 AXX stored");
        idle(2);
        round(32'h0123_4567, 32'hDEAD_BEEF, 32'h243F_6A88);
        round(32'hFFFF_FFFF, 32'h0000_0001, 32'h85A3_08D3);
        // R6 plain add
        step(1, 3'd4, 5'd11, 0, 0, 0, 1, "R6 AX nox");
        step(1, 3'd5, 5'd12, 0, 32'h1, 32'h2, 0, "R6 AXX after nox");
        // R10 ignored issues then a probe of stored words
        step(0, 3'd0, 5'd1, 32'h5555_5555, 0, 0, 0, "R10");
        step(1, 3'd6, 5'd1, 32'h6666_6666, 0, 0, 0, "R10");
        step(1, 3'd7, 5'd1, 32'h7777_7777, 0, 0, 0, "R10");
        step(0, 3'd4, 5'd1, 0, 0, 0, 0, "R10");
        idle(2);
        step(1, 3'd4, 5'd13, 0, 0, 0, 0, "R10 AX probe");
        step(1, 3'd5, 5'd14, 0, 32'hAAAA_0000, 32'h0000_5555, 0, "R10 AXX probe");
        for (int k = 0; k < 4; k++) begin
            round(32'h9E37_79B9 * 32'(k + 3), 32'(k) * 32'h1111_1111, 32'hB7E1_5163 ^ 32'(k));
        end
        round(32'h0000_0000, 32'hFFFF_FFFF, 32'h0);
        idle(4);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #200000;
        total++;
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule